// File: doc/BRIEF.md
# Card Window Address Translator

This block keeps the setup of three address windows for one card socket and turns host accesses into card accesses. The host address is split in two: the top two bits pick a window and the low 20 bits are an offset inside that window's 1 MB span. Each window points its span at one 1 MB page of a 64 MB card space. It also names the space the access goes to: attribute memory, common memory or I/O.

Each window has two 16-bit control words. They are written and read through a small byte-offset register port. The first word holds the page, the space code and the command strobe length and delay. The second word holds the recovery delay, the wait delay and a flag that says a wait signal is needed.

One cycle after a host request, the block presents one of three results:
- the card address, the space code and the timing fields of the chosen window, for a bus sequencer downstream;
- an unmapped flag, when the window number is out of range;
- a space error, when the window holds the unused space code.

Top module: `card_window_xlat`

## Requirements
- R1: After reset every window control word reads as 0 and no result output (card_valid, space_err, unmapped) is high.
- R2: The first control word of window w (0..2) is at byte offset 4w. Its bit 15 always reads 0 and ignores writes. Bits 14..0 read back what was written.
- R3: The second control word of window w is at byte offset 4w+2. Bits 15..5 always read 0 and ignore writes. Bits 4..0 read back what was written.
- R4: Any other offset of the 32-byte bank reads 0, and a write to it changes no window word. This covers offsets 12 to 31 and every odd offset.
- R5: A host request raises card_valid in the next cycle when the window is mapped and its space code is legal. card_addr is then {page, host offset}: the page is bits 5..0 of the window's first word and the offset is host_addr[19:0].
- R6: With card_valid, card_space equals bits 7..6 of the window's first word. The codes are 00 attribute memory, 01 common memory and 10 I/O.
- R7: If the window's space code is 11, the next cycle shows space_err high and card_valid low. card_addr, card_space and all timing outputs are 0.
- R8: If host_addr[21:20] is 3, the next cycle shows unmapped high and card_valid low, with the address, space and timing outputs at 0.
- R9: With card_valid, the timing outputs come from the chosen window:
  - strobe_len = first word bits 14..10;
  - strobe_dly = first word bits 9..8;
  - recov_dly = second word bits 4..3;
  - wait_dly = second word bits 2..1;
  - wait_need = second word bit 0.
- R10: In a cycle after no request, card_valid, space_err and unmapped are all low. At most one of the three is high in any cycle.
- R11: A register write takes effect at the clock edge that ends the write cycle. A request in that same cycle is translated with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| host_req | input | 1 | Host access request |
| host_addr | input | 22 | Host address: [21:20] window, [19:0] offset |
| card_valid | output | 1 | Translated access is valid |
| card_addr | output | 26 | Card address |
| card_space | output | 2 | Card space code |
| space_err | output | 1 | Request hit a window with space code 11 |
| unmapped | output | 1 | Request named no window |
| strobe_len | output | 5 | Command strobe length |
| strobe_dly | output | 2 | Command strobe delay |
| recov_dly | output | 2 | Recovery delay |
| wait_dly | output | 2 | Wait signal delay |
| wait_need | output | 1 | Wait signal required |

## Verification
A corrupted window word appears at the register port as soon as its offset is read. It also shows in the very next translated result of that window, as a wrong page in card_addr, a wrong space code or wrong timing fields. A wrong decode of the window number or of the space code shows one cycle after the request: the wrong flag among card_valid, space_err and unmapped is raised. Any flag left high after an idle cycle is visible immediately. The scoreboard compares every result cycle and every idle cycle against a shadow model of the registers.

// File: rtl/card_window_xlat.sv
module card_window_xlat #(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = 6,
  parameter int OFF_W   = 20,
  parameter int SEL_W   = 2,
  parameter int RA_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [RA_W-1:0]           reg_addr,
  input  logic [15:0]               reg_wdata,
  output logic [15:0]               reg_rdata,
  input  logic                      host_req,
  input  logic [SEL_W+OFF_W-1:0]    host_addr,
  output logic                      card_valid,
  output logic [PAGE_W+OFF_W-1:0]   card_addr,
  output logic [1:0]                card_space,
  output logic                      space_err,
  output logic                      unmapped,
  output logic [4:0]                strobe_len,
  output logic [1:0]                strobe_dly,
  output logic [1:0]                recov_dly,
  output logic [1:0]                wait_dly,
  output logic                      wait_need
);
  localparam int HOST_AW = SEL_W + OFF_W;
  localparam int CARD_AW = PAGE_W + OFF_W;
  localparam logic [15:0] W0_MASK = 16'h7FFF;
  localparam logic [15:0] W1_MASK = 16'h001F;
  localparam logic [1:0]  SP_BAD  = 2'b11;

  logic [15:0] w0 [NUM_WIN];
  logic [15:0] w1 [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w0[w] <= '0;
        w1[w] <= '0;
      end else if (reg_we) begin
        if (reg_addr == RA_W'(4*w))     w0[w] <= reg_wdata & W0_MASK;
        if (reg_addr == RA_W'(4*w + 2)) w1[w] <= reg_wdata & W1_MASK;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (reg_addr == RA_W'(4*w))     reg_rdata = w0[w];
      if (reg_addr == RA_W'(4*w + 2)) reg_rdata = w1[w];
    end
  end

  logic [SEL_W-1:0] sel;
  logic [15:0]      s0, s1;
  logic             in_range, bad_sp, hit;

  assign sel = host_addr[HOST_AW-1:OFF_W];

  always_comb begin
    s0 = '0;
    s1 = '0;
    in_range = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel == SEL_W'(w)) begin
        s0 = w0[w];
        s1 = w1[w];
        in_range = 1'b1;
      end
    end
  end

  assign bad_sp = (s0[7:6] == SP_BAD);
  assign hit    = in_range && !bad_sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_valid <= 1'b0;
      space_err  <= 1'b0;
      unmapped   <= 1'b0;
      card_addr  <= '0;
      card_space <= '0;
      strobe_len <= '0;
      strobe_dly <= '0;
      recov_dly  <= '0;
      wait_dly   <= '0;
      wait_need  <= 1'b0;
    end else begin
      card_valid <= host_req && hit;
      space_err  <= host_req && in_range && bad_sp;
      unmapped   <= host_req && !in_range;
      if (host_req && hit) begin
        card_addr  <= CARD_AW'({s0[PAGE_W-1:0], host_addr[OFF_W-1:0]});
        card_space <= s0[7:6];
        strobe_len <= s0[14:10];
        strobe_dly <= s0[9:8];
        recov_dly  <= s1[4:3];
        wait_dly   <= s1[2:1];
        wait_need  <= s1[0];
      end else begin
        card_addr  <= '0;
        card_space <= '0;
        strobe_len <= '0;
        strobe_dly <= '0;
        recov_dly  <= '0;
        wait_dly   <= '0;
        wait_need  <= 1'b0;
      end
    end
  end
endmodule

module card_window_xlat_chk #(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = 6,
  parameter int OFF_W   = 20,
  parameter int SEL_W   = 2,
  parameter int RA_W    = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [RA_W-1:0]         reg_addr,
  input logic [15:0]             reg_rdata,
  input logic                    host_req,
  input logic [SEL_W+OFF_W-1:0]  host_addr,
  input logic                    card_valid,
  input logic [PAGE_W+OFF_W-1:0] card_addr,
  input logic                    space_err,
  input logic                    unmapped
);
  AST_W0_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15] == 1'b0); // R2
  AST_W1_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] == 2'b10) |-> (reg_rdata[15:5] == '0)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    card_valid |-> (card_addr[OFF_W-1:0] == $past(host_addr[OFF_W-1:0]))); // R5
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    space_err |-> (!card_valid && !unmapped && card_addr == '0)); // R7
  AST_UNMAPPED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_req) && (32'($past(host_addr[SEL_W+OFF_W-1:OFF_W])) >= NUM_WIN))
      |-> (unmapped && !card_valid)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_req) |-> !(card_valid || space_err || unmapped)); // R10
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_valid, space_err, unmapped})); // R10
endmodule

bind card_window_xlat card_window_xlat_chk #(
  .NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SEL_W(SEL_W), .RA_W(RA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .host_req(host_req), .host_addr(host_addr), .card_valid(card_valid),
  .card_addr(card_addr), .space_err(space_err), .unmapped(unmapped)
);

// File: tb/card_window_xlat_bench.sv
module card_window_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_req = 1'b0;
  logic [21:0] host_addr = '0;
  logic        card_valid, space_err, unmapped, wait_need;
  logic [25:0] card_addr;
  logic [1:0]  card_space, strobe_dly, recov_dly, wait_dly;
  logic [4:0]  strobe_len;

  always #5 clk = ~clk;

  card_window_xlat u_card_window_xlat (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
    .host_addr(host_addr), .card_valid(card_valid), .card_addr(card_addr),
    .card_space(card_space), .space_err(space_err), .unmapped(unmapped),
    .strobe_len(strobe_len), .strobe_dly(strobe_dly), .recov_dly(recov_dly),
    .wait_dly(wait_dly), .wait_need(wait_need)
  );

  typedef struct packed {
    logic v, e, u;
    logic [25:0] a;
    logic [1:0] sp;
    logic [4:0] sl;
    logic [1:0] sd, rd, wd;
    logic wn;
  } res_t;

  int errors = 0, checks = 0;
  logic [15:0] sh0 [3];
  logic [15:0] sh1 [3];
  res_t q[$];
  string tags[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_read(input logic [4:0] a);
    if (a[0] == 1'b0 && a < 5'd12) return a[1] ? sh1[a[4:2]] : sh0[a[4:2]];
    return 16'h0;
  endfunction

  function automatic res_t mdl_xlat(input logic [21:0] ha);
    res_t r = '0;
    int w = int'(ha[21:20]);
    if (w > 2) r.u = 1'b1;
    else if (sh0[w][7:6] == 2'b11) r.e = 1'b1;
    else begin
      r.v = 1'b1;
      r.a = {sh0[w][5:0], ha[19:0]};
      r.sp = sh0[w][7:6];
      r.sl = sh0[w][14:10];
      r.sd = sh0[w][9:8];
      r.rd = sh1[w][4:3];
      r.wd = sh1[w][2:1];
      r.wn = sh1[w][0];
    end
    return r;
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a[0] == 1'b0 && a < 5'd12) begin
      if (a[1]) sh1[a[4:2]] = d & 16'h001F;
      else      sh0[a[4:2]] = d & 16'h7FFF;
    end
  endtask

  task automatic reg_read(input logic [4:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == mdl_read(a), tag, 64'(reg_rdata), 64'(mdl_read(a)));
  endtask

  task automatic access(input logic [21:0] ha, input string tag);
    @(negedge clk);
    host_req = 1'b1; host_addr = ha;
    q.push_back(mdl_xlat(ha));
    tags.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_req = 1'b0;
    end
  endtask

  initial begin : monitor
    forever begin
      logic seen;
      res_t got, want;
      string tg;
      @(posedge clk);
      seen = host_req;
      #1;
      if (rst_n) begin
        got = {card_valid, space_err, unmapped, card_addr, card_space,
               strobe_len, strobe_dly, recov_dly, wait_dly, wait_need};
        if (seen) begin
          if (q.size() == 0) chk(1'b0, "scoreboard underrun", 64'(got), 64'(0));
          else begin
            want = q.pop_front();
            tg = tags.pop_front();
            chk(got == want, tg, 64'(got), 64'(want));
          end
        end else begin
          chk(!(card_valid || space_err || unmapped), "R10 idle cycle quiet",
              64'({card_valid, space_err, unmapped}), 64'(0));
        end
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 3; i++) begin sh0[i] = '0; sh1[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(card_valid || space_err || unmapped), "R1 outputs idle after reset",
        64'({card_valid, space_err, unmapped}), 64'(0));
    for (int a = 0; a < 12; a += 2) reg_read(5'(a), "R1 window word zero after reset");

    reg_write(5'd0, 16'hFFFF);
    reg_read(5'd0, "R2 first word bit15 reads zero");
    reg_write(5'd2, 16'hFFFF);
    reg_read(5'd2, "R3 second word bits 15..5 read zero");
    access(22'h0_1234, "R7 space code 11 gives space_err");
    idle(1);

    reg_write(5'd1, 16'hAAAA);
    reg_write(5'd12, 16'hFFFF);
    reg_write(5'd16, 16'h1234);
    reg_write(5'd30, 16'hFFFF);
    reg_write(5'd7, 16'h5555);
    reg_read(5'd0, "R4 odd/unused writes leave window 0 word");
    reg_read(5'd2, "R4 odd/unused writes leave window 0 second word");
    reg_read(5'd4, "R4 unused writes leave window 1 word");
    reg_read(5'd12, "R4 offset 12 reads zero");
    reg_read(5'd16, "R4 offset 16 reads zero");
    reg_read(5'd1, "R4 odd offset reads zero");

    reg_write(5'd0, 16'((5'h15 << 10) | (2 << 8) | (1 << 6) | 6'h3F));
    reg_write(5'd2, 16'h0013);
    reg_write(5'd4, 16'((5'h0A << 10) | (1 << 8) | (0 << 6) | 6'h05));
    reg_write(5'd6, 16'h000C);
    reg_write(5'd8, 16'((5'h1F << 10) | (3 << 8) | (2 << 6) | 6'h20));
    reg_write(5'd10, 16'h0007);
    for (int a = 0; a < 12; a += 2) reg_read(5'(a), "R2 R3 configured readback");

    access(22'h0_0000, "R5 R6 R9 window 0 common memory low offset");
    access(22'h0_FFFF, "R5 R9 window 0 high offset");
    access(22'h1_ABCDE, "R5 R6 R9 window 1 attribute memory");
    access(22'h2_54321, "R5 R6 R9 window 2 I/O");
    access(22'h3_00010, "R8 window select 3 unmapped");
    access(22'h1_00001, "R5 after unmapped back to back");
    idle(2);
    access(22'h3_FFFFF, "R8 unmapped top address");
    idle(1);

    reg_write(5'd4, 16'h00C1);
    access(22'h1_00042, "R7 window 1 space 11 error");
    idle(1);

    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 16'h0041;
    host_req = 1'b1; host_addr = 22'h2_00077;
    q.push_back(mdl_xlat(22'h2_00077));
    tags.push_back("R11 same-cycle request uses old word");
    @(negedge clk);
    reg_we = 1'b0;
    sh0[2] = 16'h0041;
    host_req = 1'b1; host_addr = 22'h2_00078;
    q.push_back(mdl_xlat(22'h2_00078));
    tags.push_back("R11 next request uses new word");
    idle(3);
    reg_read(5'd8, "R11 written word visible");

    chk(q.size() == 0, "scoreboard drained", 64'(q.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule